// File: doc/BRIEF.md
# PCI configuration address generator

This block sits in a host-to-PCI bridge and turns a software configuration request into one bus cycle. A request carries a bus number, a combined device/function byte, a register byte offset, an access size in bytes and a read/write flag. The block decides whether the target sits on the local bus or behind a bridge. It builds the matching configuration address. It then places that address in a sparse window, where the access size rides in the low address bits, and drives a control bit that tells the bus interface which cycle type to run.

Write data is moved onto the byte lanes selected by the low two bits of the offset. Read data coming back is moved down by the same amount, so the requester always sees its value right-aligned. Requests that name an unreachable local device, or that ask for an unsupported size, are answered at once with an error status and never reach the bus. Requests and responses each use a valid/ready handshake, and only one request is in flight at a time.

Top module: `pci_cfg_addr_gen`

## Requirements
- R1: `req_ready` is high only while no request is in flight. After a request is accepted, it stays low until the response has been taken with `rsp_valid` and `rsp_ready` both high.
- R2: A request with bus number 0 produces a local cycle with `cyc_type1` = 0 and configuration address bits 1:0 = 00. Any other bus number produces a forwarded cycle with `cyc_type1` = 1 and bits 1:0 = 01.
- R3: For a local cycle, the configuration address has exactly one select bit among bits 23:11, at position 11 + device. Here the device is `req_devfn[7:3]`. Bits 10:8 hold the function `req_devfn[2:0]` and bits 7:2 hold `req_reg[7:2]`.
- R4: On bus 0, a device number above `MAX_DEV` (12) issues no bus cycle. The response then carries status 01 (no device) and read data of all ones.
- R5: For a forwarded cycle, the configuration address holds the bus number in bits 23:16, `req_devfn` in bits 15:8 and `req_reg[7:2]` in bits 7:2.
- R6: `cyc_addr` equals `CFG_BASE` + (configuration address × 32) + (size − 1) × 8.
- R7: A size other than 1, 2 or 4 issues no bus cycle. The response carries status 10 (illegal) and read data of all ones. This check takes precedence over the device check.
- R8: On writes, `cyc_wdata` is `req_wdata` shifted left by 8 × `req_reg[1:0]` and truncated to 32 bits.
- R9: On a completed read, `rsp_rdata` is `cyc_rdata` shifted right by 8 × offset[1:0], with status 00. A completed write returns status 00 and data 0.
- R10: While `cyc_valid` is high, it stays high together with a stable `cyc_addr`, `cyc_type1`, `cyc_write` and `cyc_wdata` until `cyc_done` is seen.
- R11: While `rsp_valid` is high and `rsp_ready` is low, `rsp_valid`, `rsp_status` and `rsp_rdata` hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block can take a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_bus | input | 8 | Bus number |
| req_devfn | input | 8 | Device (7:3) and function (2:0) |
| req_reg | input | 8 | Register byte offset |
| req_size | input | 3 | Access size in bytes |
| req_wdata | input | 32 | Right-aligned write data |
| cyc_valid | output | 1 | Bus cycle requested |
| cyc_addr | output | ADDR_W | Sparse-space byte address |
| cyc_type1 | output | 1 | Cycle-type control bit |
| cyc_write | output | 1 | Bus cycle is a write |
| cyc_wdata | output | 32 | Lane-aligned write data |
| cyc_done | input | 1 | Bus cycle finished |
| cyc_rdata | input | 32 | Lane-aligned read data, valid with cyc_done |
| rsp_valid | output | 1 | Response present |
| rsp_ready | input | 1 | Requester takes the response |
| rsp_status | output | 2 | 00 ok, 01 no device, 10 illegal size |
| rsp_rdata | output | 32 | Right-aligned read data |

## Verification
The assertions assume that the bus side raises `cyc_done` only while `cyc_valid` is high. They also assume that the requester keeps its request fields steady for the cycle in which it is accepted. The bench meets both conditions. It pulses `cyc_done` only in the bus phase of its own model, and it drives request fields at the falling edge, removing them right after the accepting edge. Rejected requests are sent through the same handshake as legal ones. This lets the per-clock comparison show that no bus phase ever appears for them.

// File: rtl/pci_cfg_addr_gen.sv
module pci_cfg_addr_gen #(
  parameter int ADDR_W = 34,
  parameter logic [ADDR_W-1:0] CFG_BASE = 34'h2_0000_0000,
  parameter int MAX_DEV = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [7:0]        req_bus,
  input  logic [7:0]        req_devfn,
  input  logic [7:0]        req_reg,
  input  logic [2:0]        req_size,
  input  logic [31:0]       req_wdata,
  output logic              cyc_valid,
  output logic [ADDR_W-1:0] cyc_addr,
  output logic              cyc_type1,
  output logic              cyc_write,
  output logic [31:0]       cyc_wdata,
  input  logic              cyc_done,
  input  logic [31:0]       cyc_rdata,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic [1:0]        rsp_status,
  output logic [31:0]       rsp_rdata
);
  localparam int CFG_W = 24;
  localparam int SHIFT = 5;
  localparam int SEL_LO = 11;
  localparam logic [1:0] ST_OK = 2'b00, ST_NODEV = 2'b01, ST_ILL = 2'b10;

  typedef enum logic [1:0] {IDLE, BUS, RESP} state_t;
  state_t state;

  logic              r_write, r_type1;
  logic [1:0]        r_lane, r_status;
  logic [ADDR_W-1:0] r_addr;
  logic [31:0]       r_wdata, r_rdata;

  wire [4:0] dev     = req_devfn[7:3];
  wire       type1   = req_bus != 8'd0;
  wire       size_ok = req_size == 3'd1 || req_size == 3'd2 || req_size == 3'd4;
  wire       dev_ok  = type1 || 32'(dev) <= MAX_DEV;
  wire [1:0] status  = !size_ok ? ST_ILL : !dev_ok ? ST_NODEV : ST_OK;
  wire       accept  = req_valid && req_ready;

  logic [CFG_W-1:0] cfg;
  always_comb begin
    if (type1)
      cfg = {req_bus, req_devfn, req_reg[7:2], 2'b01};
    else
      cfg = (CFG_W'(1) << (SEL_LO + 32'(dev))) | {13'd0, req_devfn[2:0], req_reg[7:2], 2'b00};
  end

  wire [2:0]        size_m1  = req_size - 3'd1;
  wire [ADDR_W-1:0] addr_nxt = CFG_BASE + (ADDR_W'(cfg) << SHIFT) + ADDR_W'({size_m1, 3'b000});

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state    <= IDLE;
      r_write  <= 1'b0;
      r_type1  <= 1'b0;
      r_lane   <= 2'd0;
      r_status <= ST_OK;
      r_addr   <= '0;
      r_wdata  <= '0;
      r_rdata  <= '0;
    end else begin
      case (state)
        IDLE: if (accept) begin
          r_write  <= req_write;
          r_type1  <= type1;
          r_lane   <= req_reg[1:0];
          r_status <= status;
          r_addr   <= addr_nxt;
          r_wdata  <= req_wdata << {req_reg[1:0], 3'b000};
          r_rdata  <= '1;
          state    <= (status == ST_OK) ? BUS : RESP;
        end
        BUS: if (cyc_done) begin
          r_rdata <= r_write ? 32'd0 : cyc_rdata >> {r_lane, 3'b000};
          state   <= RESP;
        end
        RESP: if (rsp_ready) state <= IDLE;
        default: state <= IDLE;
      endcase
    end
  end

  assign req_ready  = state == IDLE;
  assign cyc_valid  = state == BUS;
  assign cyc_addr   = r_addr;
  assign cyc_type1  = r_type1;
  assign cyc_write  = r_write;
  assign cyc_wdata  = r_wdata;
  assign rsp_valid  = state == RESP;
  assign rsp_status = r_status;
  assign rsp_rdata  = r_rdata;

  wire [ADDR_W-1:0] chk_off = cyc_addr - CFG_BASE;

  // R1
  busy_after_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> !req_ready);
  // R1
  ready_after_rsp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && rsp_ready |=> req_ready);
  // R2
  type_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cyc_valid |-> chk_off[SHIFT+1:SHIFT] == {1'b0, cyc_type1});
  // R3
  local_sel_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cyc_valid && !cyc_type1 |-> $countones(chk_off[SHIFT+CFG_W-1:SHIFT+SEL_LO]) == 1);
  // R4 R7
  reject_no_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    accept && status != ST_OK |=> !cyc_valid && rsp_valid && rsp_rdata == 32'hFFFF_FFFF);
  // R10
  cyc_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cyc_valid && !cyc_done |=> cyc_valid && $stable(cyc_addr) && $stable(cyc_type1)
      && $stable(cyc_write) && $stable(cyc_wdata));
  // R11
  rsp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_ready |=> rsp_valid && $stable(rsp_status) && $stable(rsp_rdata));
  // R1
  phase_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({req_ready, cyc_valid, rsp_valid}));
endmodule

// File: tb/tb_pci_cfg_addr_gen.sv
module tb_pci_cfg_addr_gen;
  localparam int ADDR_W = 34;
  localparam logic [ADDR_W-1:0] BASE = 34'h2_0000_0000;

  logic clk = 0, rst_n = 0;
  logic req_valid = 0, req_write = 0, cyc_done = 0, rsp_ready = 0;
  logic [7:0] req_bus = 0, req_devfn = 0, req_reg = 0;
  logic [2:0] req_size = 0;
  logic [31:0] req_wdata = 0, cyc_rdata = 0;
  logic req_ready, cyc_valid, cyc_type1, cyc_write, rsp_valid;
  logic [ADDR_W-1:0] cyc_addr;
  logic [31:0] cyc_wdata, rsp_rdata;
  logic [1:0] rsp_status;

  int checks = 0, fails = 0;
  int phase = 0;
  bit mon_on = 0, done_flag = 0;

  always #4 clk = ~clk;

  pci_cfg_addr_gen dut (.clk, .rst_n, .req_valid, .req_ready, .req_write, .req_bus,
    .req_devfn, .req_reg, .req_size, .req_wdata, .cyc_valid, .cyc_addr, .cyc_type1,
    .cyc_write, .cyc_wdata, .cyc_done, .cyc_rdata, .rsp_valid, .rsp_ready,
    .rsp_status, .rsp_rdata);

  task automatic chk(string req, longint act, longint exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  always @(negedge clk) begin
    #2;
    if (mon_on) begin
      chk("R1 req_ready phase", req_ready, phase == 0);
      chk("R10 cyc_valid phase", cyc_valid, phase == 1);
      chk("R11 rsp_valid phase", rsp_valid, phase == 2);
    end
  end

  task automatic run(bit wr, logic [7:0] bus, logic [7:0] devfn, logic [7:0] rg,
                     logic [2:0] sz, logic [31:0] wd, logic [31:0] bus_rd);
    longint cfg, exp_addr;
    int dev = devfn[7:3];
    int lane = rg[1:0];
    bit szok = (sz == 1 || sz == 2 || sz == 4);
    int st = !szok ? 2 : (bus == 0 && dev > 12) ? 1 : 0;
    @(negedge clk);
    req_valid = 1; req_write = wr; req_bus = bus; req_devfn = devfn;
    req_reg = rg; req_size = sz; req_wdata = wd;
    @(posedge clk);
    @(negedge clk);
    req_valid = 0;
    if (st != 0) begin
      phase = 2;
      chk("R4 R7 status", rsp_status, st);
      chk("R4 R7 rdata", rsp_rdata, 32'hFFFF_FFFF);
    end else begin
      phase = 1;
      if (bus == 0) cfg = (longint'(1) << (11 + dev)) | (longint'(devfn[2:0]) << 8) | (rg & 8'hFC);
      else cfg = (longint'(bus) << 16) | (longint'(devfn) << 8) | (rg & 8'hFC) | 1;
      exp_addr = longint'(BASE) + (cfg << 5) + (sz - 1) * 8;
      chk(bus == 0 ? "R3 R6 local addr" : "R5 R6 fwd addr", cyc_addr, exp_addr);
      chk("R2 type bit", cyc_type1, bus != 0);
      chk("R2 write flag", cyc_write, wr);
      if (wr) chk("R8 wdata lanes", cyc_wdata, (longint'(wd) << (8 * lane)) & 32'hFFFF_FFFF);
      @(negedge clk);
      chk("R10 addr held", cyc_addr, exp_addr);
      cyc_done = 1; cyc_rdata = bus_rd;
      @(negedge clk);
      cyc_done = 0; phase = 2;
      chk("R9 status ok", rsp_status, 0);
      chk("R9 rdata", rsp_rdata, wr ? 0 : (longint'(bus_rd) >> (8 * lane)));
    end
    @(negedge clk);
    chk("R11 status held", rsp_status, st);
    rsp_ready = 1;
    @(negedge clk);
    rsp_ready = 0; phase = 0;
    chk("R1 ready again", req_ready, 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R1 reset ready", req_ready, 1);
    chk("R1 reset cyc_valid", cyc_valid, 0);
    chk("R1 reset rsp_valid", rsp_valid, 0);
    mon_on = 1;
    run(0, 8'd0, {5'd0, 3'd0}, 8'h00, 3'd4, 0, 32'hDEAD_BEEF);
    run(1, 8'd0, {5'd12, 3'd5}, 8'h0D, 3'd1, 32'h0000_00A5, 0);
    run(0, 8'd0, {5'd7, 3'd2}, 8'h3E, 3'd2, 0, 32'h1234_5678);
    run(0, 8'd0, {5'd13, 3'd0}, 8'h04, 3'd4, 0, 0);
    run(1, 8'd0, {5'd31, 3'd7}, 8'h10, 3'd2, 32'h55, 0);
    run(0, 8'd5, 8'h9A, 8'h42, 3'd2, 0, 32'hCAFE_F00D);
    run(1, 8'hFF, 8'hF8, 8'hFF, 3'd4, 32'h0102_0304, 0);
    run(0, 8'd3, 8'h11, 8'h07, 3'd3, 0, 0);
    run(0, 8'd0, {5'd20, 3'd0}, 8'h00, 3'd0, 0, 0);
    run(1, 8'd0, {5'd1, 3'd0}, 8'h03, 3'd1, 32'hFFFF_FF7E, 0);
    mon_on = 0;
    if (!done_flag) begin
      done_flag = 1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done_flag) begin
      done_flag = 1;
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule